// File: doc/BRIEF.md
# ADC Result Bank Sequencer

This block keeps track of a converter's bank of result registers. A conversion counter selects the register that receives each finished conversion. Each register has a conversion-complete flag that is raised when a result is stored and dropped when software reads that register. A sticky overrun flag records that a result landed on a register whose complete flag was still set, which means data was lost or the bank drifted out of step with the input channels.

A sequence is opened by a control-register write or by an external trigger, and it can be cut short by an abort. In the single-pass mode the counter starts each sequence at zero and returns to zero when the sequence ends. In the ring mode an external trigger leaves the counter where it is, so results keep filling successive registers across sequences and wrap at the end of the bank. A control-register write or an abort clears the counter in either mode. The analog converter, the channel multiplexer and the conversion timing sit outside this block.

Top module: `adc_result_seq`

## Requirements
- R1: A synchronous active-high reset sets the counter to 0, clears every complete flag and the overrun flag, ends any sequence, and leaves every result register reading as 0.
- R2: A conversion-done strobe during an active sequence stores the data in the register selected by the counter and sets that register's complete flag. A read strobe with an index returns that register's contents on `rd_data` one cycle later.
- R3: In single-pass mode (`fifo_mode`=0), a sequence starts with the counter at 0. The counter advances by one per stored conversion. After the programmed number of conversions the counter returns to 0 and `seq_active` drops.
- R4: In ring mode (`fifo_mode`=1), an external-trigger start leaves the counter unchanged. At the end of a sequence the counter keeps the index after the last stored result.
- R5: The counter wraps from NREG-1 to 0.
- R6: A control-write start (`start_wr`) clears the counter in either mode. An abort also clears the counter in either mode and ends the sequence. Abort has priority over a start, and a start has priority over a conversion in the same cycle.
- R7: The overrun flag sets when a result is stored in a register whose complete flag is already set, in either mode. Once set, it stays set until it is cleared.
- R8: The overrun flag clears when `ovr_clr` is 1 or when a sequence starts by either start input. If a new overrun happens in the same cycle as a clear request, the flag ends up set.
- R9: A read strobe clears the read register's complete flag. A store and a read of the same register in the same cycle leave the flag set and keep the new data. That read returns the register's previous contents.
- R10: A conversion-done strobe while no sequence is active has no effect. No register is written, no flag changes and the counter does not move.
- R11: A sequence length of 0, or a length above NREG, runs NREG conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode | input | 1 | 1 = ring mode, 0 = single-pass mode |
| seq_len | input | $clog2(NREG+1) | Conversions per sequence (0 means NREG) |
| start_wr | input | 1 | Sequence start by control-register write |
| start_trig | input | 1 | Sequence start by external trigger |
| abort | input | 1 | Abort the running sequence |
| conv_done | input | 1 | A conversion finished; `conv_data` is valid |
| conv_data | input | DW | Conversion result |
| rd_en | input | 1 | Read strobe for register `rd_idx` |
| rd_idx | input | $clog2(NREG) | Register index to read |
| ovr_clr | input | 1 | Write-one-to-clear for the overrun flag |
| conv_cnt | output | $clog2(NREG) | Conversion counter (next register to be written) |
| seq_active | output | 1 | A sequence is running |
| ccf | output | NREG | Per-register conversion-complete flags |
| ovr_flag | output | 1 | Sticky overrun flag |
| rd_data | output | DW | Registered read data |

## Verification
The bench builds the block with NREG=8 and DW=10. With only eight registers, three short ring-mode sequences carry the counter across the wrap point and back onto a register whose flag is still set, and a full-length sequence (length 0) completes in eight conversions. The default of sixteen registers is covered only by elaboration. At eight entries every flag and every stored value can be read back and compared.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Per-cycle action taken by the sequencer, in priority order.
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ABORT = 2'd1,
    SEQ_START = 2'd2,
    SEQ_STORE = 2'd3
  } seq_act_e;

  // Next index in a bank of n registers, wrapping at the top.
  function automatic int unsigned next_idx(input int unsigned cur, input int unsigned n);
    return (cur == n - 1) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NREG = 16,
  parameter int CW   = $clog2(NREG),
  parameter int LW   = $clog2(NREG + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_mode,
  input  logic [LW-1:0] seq_len,
  input  logic          start_wr,
  input  logic          start_trig,
  input  logic          abort,
  input  logic          conv_done,
  output logic [CW-1:0] conv_cnt,
  output logic          seq_active,
  output logic          wr_en,
  output logic [CW-1:0] wr_idx,
  output logic          seq_begin
);

  logic [LW-1:0] done_n;
  logic [LW-1:0] done_nx;
  logic [LW-1:0] len_eff;
  logic          last;
  logic [CW-1:0] cnt_inc;
  seq_act_e      act;

  always_comb begin
    if (seq_len == '0 || seq_len > LW'(NREG)) len_eff = LW'(NREG);
    else                                      len_eff = seq_len;
  end

  always_comb begin
    if (abort)                          act = SEQ_ABORT;
    else if (start_wr || start_trig)    act = SEQ_START;
    else if (conv_done && seq_active)   act = SEQ_STORE;
    else                                act = SEQ_IDLE;
  end

  assign done_nx   = done_n + LW'(1);
  assign last      = (done_nx == len_eff);
  assign cnt_inc   = CW'(next_idx(int'(conv_cnt), NREG));
  assign wr_en     = (act == SEQ_STORE);
  assign wr_idx    = conv_cnt;
  assign seq_begin = (act == SEQ_START);

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_cnt   <= '0;
      seq_active <= 1'b0;
      done_n     <= '0;
    end else begin
      unique case (act)
        SEQ_ABORT: begin
          conv_cnt   <= '0;
          seq_active <= 1'b0;
          done_n     <= '0;
        end
        SEQ_START: begin
          seq_active <= 1'b1;
          done_n     <= '0;
          if (start_wr || !fifo_mode) conv_cnt <= '0;
        end
        SEQ_STORE: begin
          if (last) begin
            seq_active <= 1'b0;
            done_n     <= '0;
            conv_cnt   <= fifo_mode ? cnt_inc : '0;
          end else begin
            done_n   <= done_nx;
            conv_cnt <= cnt_inc;
          end
        end
        default: ;
      endcase
    end
  end

  assert_abort_clears_R6: assert property (@(posedge clk) disable iff (rst)
    abort |=> (conv_cnt == '0) && !seq_active);

  assert_wr_start_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (start_wr && !abort) |=> (conv_cnt == '0) && seq_active);

  assert_trig_keeps_cnt_R4: assert property (@(posedge clk) disable iff (rst)
    (start_trig && !start_wr && !abort && fifo_mode) |=> $stable(conv_cnt));

  assert_single_end_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && last && !fifo_mode) |=> (conv_cnt == '0) && !seq_active);

  assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && conv_cnt == CW'(NREG - 1) && (fifo_mode || !last)) |=> conv_cnt == '0);

  assert_idle_conv_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (conv_done && !seq_active && !start_wr && !start_trig && !abort) |=> $stable(conv_cnt));

  assert_cnt_range_R5: assert property (@(posedge clk) disable iff (rst)
    int'(conv_cnt) < NREG);

endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
  parameter int NREG = 16,
  parameter int CW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [CW-1:0]   wr_idx,
  input  logic            rd_en,
  input  logic [CW-1:0]   rd_idx,
  input  logic            ovr_clr,
  input  logic            seq_begin,
  output logic [NREG-1:0] ccf,
  output logic            ovr_flag
);

  logic ovr_hit;

  for (genvar i = 0; i < NREG; i++) begin : g_flag
    logic set_i;
    logic clr_i;
    assign set_i = wr_en && (wr_idx == CW'(i));
    assign clr_i = rd_en && (rd_idx == CW'(i));
    always_ff @(posedge clk) begin
      if (rst)        ccf[i] <= 1'b0;
      else if (set_i) ccf[i] <= 1'b1;
      else if (clr_i) ccf[i] <= 1'b0;
    end
  end

  assign ovr_hit = wr_en && ccf[wr_idx];

  always_ff @(posedge clk) begin
    if (rst)                       ovr_flag <= 1'b0;
    else if (ovr_hit)              ovr_flag <= 1'b1;
    else if (ovr_clr || seq_begin) ovr_flag <= 1'b0;
  end

  assert_store_sets_flag_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ccf[$past(wr_idx)]);

  assert_overrun_sets_R7: assert property (@(posedge clk) disable iff (rst)
    ovr_hit |=> ovr_flag);

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (ovr_flag && !ovr_clr && !seq_begin) |=> ovr_flag);

  assert_overrun_clear_R8: assert property (@(posedge clk) disable iff (rst)
    ((ovr_clr || seq_begin) && !ovr_hit) |=> !ovr_flag);

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !(wr_en && wr_idx == rd_idx)) |=> !ccf[$past(rd_idx)]);

endmodule

// File: rtl/result_ram.sv
module result_ram #(
  parameter int NREG = 16,
  parameter int DW   = 10,
  parameter int CW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [CW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          re,
  input  logic [CW-1:0] ra,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0]   mem [NREG];
  logic [NREG-1:0] written;

  // Storage without reset so it maps to RAM; reset clears the valid bits.
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (rst)     written <= '0;
    else if (we) written[wa] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)     rd_data <= '0;
    else if (re) rd_data <= written[ra] ? mem[ra] : '0;
  end

  assert_read_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    (re && !written[ra]) |=> rd_data == '0);

endmodule

// File: rtl/adc_result_seq.sv
module adc_result_seq #(
  parameter int NREG = 16,
  parameter int DW   = 10,
  localparam int CW  = $clog2(NREG),
  localparam int LW  = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fifo_mode,
  input  logic [LW-1:0]   seq_len,
  input  logic            start_wr,
  input  logic            start_trig,
  input  logic            abort,
  input  logic            conv_done,
  input  logic [DW-1:0]   conv_data,
  input  logic            rd_en,
  input  logic [CW-1:0]   rd_idx,
  input  logic            ovr_clr,
  output logic [CW-1:0]   conv_cnt,
  output logic            seq_active,
  output logic [NREG-1:0] ccf,
  output logic            ovr_flag,
  output logic [DW-1:0]   rd_data
);

  logic          wr_en;
  logic [CW-1:0] wr_idx;
  logic          seq_begin;

  seq_ctrl #(.NREG(NREG), .CW(CW), .LW(LW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .fifo_mode  (fifo_mode),
    .seq_len    (seq_len),
    .start_wr   (start_wr),
    .start_trig (start_trig),
    .abort      (abort),
    .conv_done  (conv_done),
    .conv_cnt   (conv_cnt),
    .seq_active (seq_active),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .seq_begin  (seq_begin)
  );

  flag_bank #(.NREG(NREG), .CW(CW)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .rd_en     (rd_en),
    .rd_idx    (rd_idx),
    .ovr_clr   (ovr_clr),
    .seq_begin (seq_begin),
    .ccf       (ccf),
    .ovr_flag  (ovr_flag)
  );

  result_ram #(.NREG(NREG), .DW(DW), .CW(CW)) u_ram (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_en),
    .wa      (wr_idx),
    .wd      (conv_data),
    .re      (rd_en),
    .ra      (rd_idx),
    .rd_data (rd_data)
  );

  assert_idle_no_flag_R10: assert property (@(posedge clk) disable iff (rst)
    (conv_done && !seq_active && !start_wr && !start_trig && !abort && !rd_en) |=> $stable(ccf));

endmodule

// File: tb/sim_adc_result_seq.sv
`timescale 1ns/1ps
module sim_adc_result_seq;
  localparam int NREG = 8;
  localparam int DW   = 10;
  localparam int CW   = $clog2(NREG);
  localparam int LW   = $clog2(NREG + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_mode = 1'b0;
  logic [LW-1:0] seq_len = '0;
  logic start_wr = 1'b0, start_trig = 1'b0, abort = 1'b0, conv_done = 1'b0;
  logic [DW-1:0] conv_data = '0;
  logic rd_en = 1'b0;
  logic [CW-1:0] rd_idx = '0;
  logic ovr_clr = 1'b0;
  logic [CW-1:0] conv_cnt;
  logic seq_active;
  logic [NREG-1:0] ccf;
  logic ovr_flag;
  logic [DW-1:0] rd_data;

  int checks = 0, errors = 0;
  int mon_checks = 0, mon_errors = 0;
  bit finished = 1'b0;
  int exp_q[$];
  logic rd_en_d = 1'b0;

  always #2.5 clk = ~clk;

  adc_result_seq #(.NREG(NREG), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .fifo_mode(fifo_mode), .seq_len(seq_len),
    .start_wr(start_wr), .start_trig(start_trig), .abort(abort),
    .conv_done(conv_done), .conv_data(conv_data), .rd_en(rd_en), .rd_idx(rd_idx),
    .ovr_clr(ovr_clr), .conv_cnt(conv_cnt), .seq_active(seq_active), .ccf(ccf),
    .ovr_flag(ovr_flag), .rd_data(rd_data)
  );

  // Monitor: compares read data against the scoreboard queue.
  always @(posedge clk) rd_en_d <= rd_en && !rst;
  always @(negedge clk) begin
    if (rd_en_d) begin
      mon_checks++;
      if (exp_q.size() == 0) begin
        mon_errors++;
        $display("FAIL R2 read data: actual %0h expected <none queued>", rd_data);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(rd_data) != e) begin
          mon_errors++;
          $display("FAIL R2/R9 read data: actual %0h expected %0h", rd_data, e);
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    start_wr = 0; start_trig = 0; abort = 0; conv_done = 0; ovr_clr = 0; rd_en = 0;
  endtask

  task automatic conv(input int d);
    conv_done = 1; conv_data = DW'(d); tick();
  endtask

  // Driver: issues a read and pushes the expected value.
  task automatic rd_push(input int idx, input int exp);
    rd_en = 1; rd_idx = CW'(idx); exp_q.push_back(exp); tick();
  endtask

  initial begin
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 cnt", int'(conv_cnt), 0);
    chk("R1 ccf", int'(ccf), 0);
    chk("R1 ovr", int'(ovr_flag), 0);
    chk("R1 active", int'(seq_active), 0);
    chk("R1 rd_data", int'(rd_data), 0);
    rst = 0;
    tick();

    // Single-pass sequence of three (R2, R3)
    fifo_mode = 0; seq_len = LW'(3);
    start_wr = 1; tick();
    chk("R3 start cnt", int'(conv_cnt), 0);
    chk("R3 active", int'(seq_active), 1);
    conv('h101);
    chk("R3 step cnt", int'(conv_cnt), 1);
    chk("R2 flag set", int'(ccf), 'h1);
    conv('h102);
    chk("R3 step cnt", int'(conv_cnt), 2);
    conv('h103);
    chk("R3 end cnt", int'(conv_cnt), 0);
    chk("R3 end active", int'(seq_active), 0);
    chk("R2 flags", int'(ccf), 'h7);
    rd_push(0, 'h101); rd_push(1, 'h102); rd_push(2, 'h103);
    chk("R9 reads clear", int'(ccf), 0);

    // Conversion outside a sequence (R10)
    conv('h3FF);
    chk("R10 cnt", int'(conv_cnt), 0);
    chk("R10 ccf", int'(ccf), 0);
    rd_push(3, 0);

    // Overrun (R7, R8)
    seq_len = LW'(2);
    start_trig = 1; tick();
    conv('h11); conv('h22);
    chk("R2 flags", int'(ccf), 'h3);
    chk("R7 no ovr", int'(ovr_flag), 0);
    start_trig = 1; tick();
    chk("R3 trig cnt", int'(conv_cnt), 0);
    conv('h33);
    chk("R7 ovr set", int'(ovr_flag), 1);
    conv('h44);
    chk("R7 ovr sticky", int'(ovr_flag), 1);
    ovr_clr = 1; tick();
    chk("R8 w1c", int'(ovr_flag), 0);
    start_trig = 1; tick();
    conv_done = 1; conv_data = DW'('h55); ovr_clr = 1; tick();
    chk("R8 set wins", int'(ovr_flag), 1);
    start_wr = 1; tick();
    chk("R8 start clears", int'(ovr_flag), 0);
    chk("R6 wr start cnt", int'(conv_cnt), 0);
    abort = 1; tick();
    chk("R6 abort active", int'(seq_active), 0);
    chk("R6 abort cnt", int'(conv_cnt), 0);
    rd_push(0, 'h55); rd_push(1, 'h44);
    chk("R9 ccf", int'(ccf), 0);

    // Ring mode across sequences (R4, R5, R7, R6)
    fifo_mode = 1; seq_len = LW'(3);
    start_wr = 1; tick();
    chk("R6 ring wr start", int'(conv_cnt), 0);
    conv('h200); conv('h201); conv('h202);
    chk("R4 end cnt", int'(conv_cnt), 3);
    chk("R4 end active", int'(seq_active), 0);
    start_trig = 1; tick();
    chk("R4 trig keeps", int'(conv_cnt), 3);
    chk("R4 active", int'(seq_active), 1);
    conv('h203); conv('h204); conv('h205);
    chk("R4 cnt", int'(conv_cnt), 6);
    start_trig = 1; tick();
    conv('h206); conv('h207);
    chk("R5 wrap", int'(conv_cnt), 0);
    chk("R7 no ovr yet", int'(ovr_flag), 0);
    conv('h208);
    chk("R7 ring ovr", int'(ovr_flag), 1);
    chk("R5 after wrap", int'(conv_cnt), 1);
    start_wr = 1; tick();
    chk("R6 ring wr clears", int'(conv_cnt), 0);
    conv('h209);
    chk("R6 pre-abort", int'(conv_cnt), 1);
    abort = 1; tick();
    chk("R6 ring abort", int'(conv_cnt), 0);
    rd_push(0, 'h209);
    for (int i = 1; i < NREG; i++) rd_push(i, 'h200 + i);
    chk("R9 all clear", int'(ccf), 0);

    // Store and read of the same register in one cycle (R9)
    fifo_mode = 0; seq_len = LW'(1);
    start_wr = 1; tick();
    conv_done = 1; conv_data = DW'('h3AA); rd_en = 1; rd_idx = '0;
    exp_q.push_back('h209); tick();
    chk("R9 flag kept", int'(ccf), 'h1);
    chk("R3 len1 end", int'(seq_active), 0);
    rd_push(0, 'h3AA);
    chk("R9 cleared", int'(ccf), 0);

    // Length 0 means the full bank (R11)
    seq_len = '0;
    start_wr = 1; tick();
    for (int k = 0; k < NREG - 1; k++) conv('h300 + k);
    chk("R11 cnt", int'(conv_cnt), NREG - 1);
    chk("R11 still active", int'(seq_active), 1);
    conv('h3FE);
    chk("R11 end cnt", int'(conv_cnt), 0);
    chk("R11 end active", int'(seq_active), 0);
    chk("R11 flags", int'(ccf), (1 << NREG) - 1);

    tick(); tick();
    chk("R2 scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks + mon_checks, errors + mon_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors",
               checks + mon_checks + 1, errors + mon_errors + 1);
      $finish;
    end
  end

endmodule